// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM of one million 16-bit words. The host hands it one request at a time over a valid/ready port: a 20-bit word address, a write flag, a two-bit byte mask and the write data. The controller turns each request into a strobe sequence on the RAM pins. That sequence consists of chip enable, write enable, output enable and one enable per byte lane, all active low. The data bus is split into a driven value, a local drive enable and a sampled input. Read results come back as a one-cycle valid pulse that carries the sampled word.

Every phase of a cycle lasts a whole number of clock cycles, and each count is a parameter. The phases are the address settling time before any strobe falls, the length of the write pulse, the wait before read data is sampled, and the idle time that lets the RAM release the bus after a read. All strobe pins and the data drive enable come straight from flops. Output enable stays high through every write, so the controller and the RAM never drive the bus at the same time. A new request is taken only while the controller is idle.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held and after it is released, before any request: req_ready is 1, ram_ce_n, ram_we_n, ram_oe_n and both ram_be_n bits are 1, ram_dq_oe is 0 and rdata_valid is 0.
- R2: A write runs as follows. After the accepting clock edge, all strobes stay high for SETUP_CYC cycles. Then ram_ce_n, ram_we_n and the enabled lane enables are low together for exactly WPULSE_CYC cycles. Then they all rise on the same edge.
- R3: On any clock cycle in which ram_addr differs from the previous cycle, ram_ce_n, ram_we_n and both ram_be_n bits are 1 in that cycle and in the cycle before it.
- R4: ram_dq_oe is 1 in every cycle where ram_we_n is 0 and in the one cycle after ram_we_n rises. It is 0 otherwise. While it is 1, ram_dq_out equals the request's write data.
- R5: ram_oe_n is never 0 in a cycle where ram_we_n is 0 or ram_dq_oe is 1.
- R6: A read runs as follows. After SETUP_CYC cycles with all strobes high, ram_ce_n, ram_oe_n and the enabled lane enables are low for RWAIT_CYC+1 cycles, and ram_dq_in is sampled at the end of the last of those cycles. rdata_valid is then high for exactly one cycle, SETUP_CYC+RWAIT_CYC+1 clock edges after the accepting edge.
- R7: Mask bit i selects byte lane i (data bits 8i+7..8i) and drives ram_be_n[i] low. Bit 0 is the lower lane. In rdata, the byte of every lane whose mask bit is 0 reads as zero.
- R8: A write leaves unchanged the RAM bytes of lanes whose mask bit is 0. A mask of zero writes nothing.
- R9: After a read, all strobes stay high for TURN_CYC cycles before req_ready returns to 1. While req_ready is 0, req_valid has no effect: ram_addr does not change and no new cycle starts.
- R10: After a write, req_ready returns to 1 SETUP_CYC+WPULSE_CYC+2 clock edges after the accepting edge, counting the accepting edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 20 | Word address |
| req_mask | input | 2 | Byte lane select, bit 0 = lower lane |
| req_wdata | input | 16 | Write data |
| rdata_valid | output | 1 | One-cycle pulse with read data |
| rdata | output | 16 | Read word, disabled lanes zero |
| ram_addr | output | 20 | RAM address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_be_n | output | 2 | RAM byte lane enables, active low |
| ram_dq_out | output | 16 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_out |
| ram_dq_in | input | 16 | Data read from the RAM bus |

## Verification
The bench goes after lane masking. It uses masks of zero and single-lane masks on words that already hold data. A controller that wrote through a disabled lane, or passed through the floating byte the RAM model puts on a disabled lane, gives a read that disagrees with the scoreboard. It also keeps checking that every address change falls while the strobes are high, and that output enable never overlaps a write or the data drive. A design that moved the address together with a falling strobe, or drove the bus during a read, would fail there. A directed case holds req_valid through a busy read, to catch a design that latched a second address. The latency and turnaround counts catch a phase that is one cycle short or long.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE    = 3'd0,
    SEQ_SETTLE  = 3'd1,
    SEQ_WPULSE  = 3'd2,
    SEQ_WEND    = 3'd3,
    SEQ_RWAIT   = 3'd4,
    SEQ_RSAMPLE = 3'd5,
    SEQ_TURN    = 3'd6
  } seq_state_t;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage1     <= 1'b1;
      rst_n_sync <= stage1;
    end
  end
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_bus_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int WPULSE_CYC = 1,
  parameter int RWAIT_CYC  = 1,
  parameter int TURN_CYC   = 1,
  parameter int CW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_write,
  input  logic          tmr_expired,
  output seq_state_t    state_q,
  output seq_state_t    state_d,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);
  localparam logic [CW-1:0] SETUP_LD  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] WPULSE_LD = CW'(WPULSE_CYC - 1);
  localparam logic [CW-1:0] RWAIT_LD  = CW'(RWAIT_CYC - 1);
  localparam logic [CW-1:0] TURN_LD   = CW'(TURN_CYC - 1);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d  = SEQ_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = SETUP_LD;
        end
      end
      SEQ_SETTLE: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (is_write) begin
            state_d = SEQ_WPULSE;
            tmr_val = WPULSE_LD;
          end else begin
            state_d = SEQ_RWAIT;
            tmr_val = RWAIT_LD;
          end
        end
      end
      SEQ_WPULSE:  if (tmr_expired) state_d = SEQ_WEND;
      SEQ_WEND:    state_d = SEQ_IDLE;
      SEQ_RWAIT:   if (tmr_expired) state_d = SEQ_RSAMPLE;
      SEQ_RSAMPLE: begin
        state_d  = SEQ_TURN;
        tmr_load = 1'b1;
        tmr_val  = TURN_LD;
      end
      SEQ_TURN:    if (tmr_expired) state_d = SEQ_IDLE;
      default:     state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
  parameter int LANES = 2
) (
  input  logic               lanes_on,
  input  logic [LANES-1:0]   mask,
  input  logic [8*LANES-1:0] din,
  output logic [LANES-1:0]   be_n_d,
  output logic [8*LANES-1:0] dmasked
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_n_d[g]       = ~(lanes_on & mask[g]);
    assign dmasked[8*g +: 8] = mask[g] ? din[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_bus_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int SETUP_CYC  = 1,
  parameter int WPULSE_CYC = 1,
  parameter int RWAIT_CYC  = 1,
  parameter int TURN_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW/8-1:0]   req_mask,
  input  logic [DW-1:0]     req_wdata,
  output logic              rdata_valid,
  output logic [DW-1:0]     rdata,
  output logic [AW-1:0]     ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DW/8-1:0]   ram_be_n,
  output logic [DW-1:0]     ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DW-1:0]     ram_dq_in
);
  localparam int LANES   = DW / 8;
  localparam int MAX_CYC = int'(max4(SETUP_CYC, WPULSE_CYC, RWAIT_CYC, TURN_CYC));
  localparam int CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic              rst_n_s;
  seq_state_t        state_q, state_d;
  logic              tmr_load, tmr_expired;
  logic [CW-1:0]     tmr_val;
  logic              accept;
  logic              wr_q;
  logic [LANES-1:0]  mask_q;
  logic              lanes_on_d, ce_n_d, we_n_d, oe_n_d, dq_oe_d;
  logic [LANES-1:0]  be_n_d;
  logic [DW-1:0]     din_masked;
  logic              capture;

  sram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign req_ready = (state_q == SEQ_IDLE);
  assign accept    = req_valid & req_ready;

  sram_seq_fsm #(
    .SETUP_CYC  (SETUP_CYC),
    .WPULSE_CYC (WPULSE_CYC),
    .RWAIT_CYC  (RWAIT_CYC),
    .TURN_CYC   (TURN_CYC),
    .CW         (CW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start       (accept),
    .is_write    (wr_q),
    .tmr_expired (tmr_expired),
    .state_q     (state_q),
    .state_d     (state_d),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val)
  );

  sram_phase_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  // Request capture: the address moves only on the accepting edge,
  // and every strobe is high on both sides of that edge.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ram_addr   <= '0;
      wr_q       <= 1'b0;
      mask_q     <= '0;
      ram_dq_out <= '0;
    end else if (accept) begin
      ram_addr   <= req_addr;
      wr_q       <= req_write;
      mask_q     <= req_mask;
      ram_dq_out <= req_wdata;
    end
  end

  // Pin values decoded from the next state, then registered.
  always_comb begin
    lanes_on_d = (state_d == SEQ_WPULSE) || (state_d == SEQ_RWAIT) ||
                 (state_d == SEQ_RSAMPLE);
    ce_n_d     = ~lanes_on_d;
    we_n_d     = ~(state_d == SEQ_WPULSE);
    oe_n_d     = ~((state_d == SEQ_RWAIT) || (state_d == SEQ_RSAMPLE));
    dq_oe_d    = (state_d == SEQ_WPULSE) || (state_d == SEQ_WEND);
  end

  sram_lane_gate #(.LANES(LANES)) u_lanes (
    .lanes_on (lanes_on_d),
    .mask     (mask_q),
    .din      (ram_dq_in),
    .be_n_d   (be_n_d),
    .dmasked  (din_masked)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ram_ce_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      ram_oe_n  <= 1'b1;
      ram_be_n  <= '1;
      ram_dq_oe <= 1'b0;
    end else begin
      ram_ce_n  <= ce_n_d;
      ram_we_n  <= we_n_d;
      ram_oe_n  <= oe_n_d;
      ram_be_n  <= be_n_d;
      ram_dq_oe <= dq_oe_d;
    end
  end

  assign capture = (state_q == SEQ_RSAMPLE);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     rdata <= '0;
    else if (capture) rdata <= din_masked;
  end
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int WPULSE_CYC = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rdata_valid,
  input logic [DW-1:0]   rdata,
  input logic [DW/8-1:0] mask_q,
  input logic [AW-1:0]   ram_addr,
  input logic            ram_ce_n,
  input logic            ram_we_n,
  input logic            ram_oe_n,
  input logic [DW/8-1:0] ram_be_n,
  input logic            ram_dq_oe
);
  logic [15:0] we_low_run;
  logic        strobes_idle;
  logic [DW-1:0] lane_bits;

  assign strobes_idle = ram_ce_n & ram_we_n & (&ram_be_n);

  always_comb begin
    for (int i = 0; i < DW/8; i++) lane_bits[8*i +: 8] = {8{mask_q[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_run <= '0;
    else if (!ram_we_n) we_low_run <= we_low_run + 1'b1;
    else                we_low_run <= '0;
  end

  assert_wpulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_low_run == 16'(WPULSE_CYC)));

  assert_addr_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ram_addr) |-> (strobes_idle && $past(strobes_idle)));

  assert_drive_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_dq_oe);

  assert_drive_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (ram_dq_oe ##1 !ram_dq_oe));

  assert_no_oe_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n || ram_dq_oe) |-> ram_oe_n);

  assert_rvalid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid);

  assert_lane_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> ((rdata & ~lane_bits) == '0));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
  .AW         (AW),
  .DW         (DW),
  .WPULSE_CYC (WPULSE_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rdata_valid (rdata_valid),
  .rdata       (rdata),
  .mask_q      (mask_q),
  .ram_addr    (ram_addr),
  .ram_ce_n    (ram_ce_n),
  .ram_we_n    (ram_we_n),
  .ram_oe_n    (ram_oe_n),
  .ram_be_n    (ram_be_n),
  .ram_dq_oe   (ram_dq_oe)
);

// File: tb/sim_sram_bus_ctrl.sv
module sim_sram_bus_ctrl;
  localparam int CLK_P      = 10;
  localparam int AW         = 20;
  localparam int DW         = 16;
  localparam int SETUP_CYC  = 1;
  localparam int WPULSE_CYC = 1;
  localparam int RWAIT_CYC  = 1;
  localparam int TURN_CYC   = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_mask;
  logic [DW-1:0] req_wdata;
  logic          rdata_valid;
  logic [DW-1:0] rdata;
  logic [AW-1:0] ram_addr;
  logic          ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [1:0]    ram_be_n;
  logic [DW-1:0] ram_dq_out, ram_dq_in;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;

  logic [15:0] mem [0:255];
  logic [15:0] sb  [0:255];

  always #(CLK_P/2) clk = ~clk;

  sram_bus_ctrl #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .WPULSE_CYC(WPULSE_CYC),
    .RWAIT_CYC(RWAIT_CYC), .TURN_CYC(TURN_CYC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_mask(req_mask),
    .req_wdata(req_wdata), .rdata_valid(rdata_valid), .rdata(rdata),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_be_n(ram_be_n), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // RAM model: drives only in read mode; a disabled or floating lane shows junk.
  always_comb begin
    ram_dq_in = 16'hC3C3;
    if (!ram_ce_n && ram_we_n && !ram_oe_n) begin
      ram_dq_in[7:0]  = ram_be_n[0] ? 8'h5A : mem[ram_addr[7:0]][7:0];
      ram_dq_in[15:8] = ram_be_n[1] ? 8'hA5 : mem[ram_addr[7:0]][15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_keep(input logic [1:0] m, input logic [15:0] d);
    return {m[1] ? d[15:8] : 8'h00, m[0] ? d[7:0] : 8'h00};
  endfunction

  function automatic logic [15:0] merge(input logic [1:0] m, input logic [15:0] old,
                                        input logic [15:0] d);
    return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
  endfunction

  // Bus monitor and RAM write port.
  logic [AW-1:0] prev_addr;
  logic          prev_idle;
  int            we_run;
  bit            post_we;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
      prev_addr <= '0;
      prev_idle <= 1'b1;
      we_run    <= 0;
      post_we   <= 1'b0;
    end else if (mon_on) begin
      if (ram_addr != prev_addr)
        chk(prev_idle && ram_ce_n && ram_we_n && (&ram_be_n), "R3 addr change",
            {ram_ce_n, ram_we_n, ram_be_n}, 4'hF);
      if ((!ram_we_n || ram_dq_oe) && !ram_oe_n)
        chk(1'b0, "R5 oe overlap", ram_oe_n, 1);
      if (!ram_we_n && !ram_dq_oe)
        chk(1'b0, "R4 no drive in pulse", ram_dq_oe, 1);
      if (post_we)
        chk(!ram_dq_oe, "R4 drive release", ram_dq_oe, 0);
      if (!ram_we_n && ram_ce_n)
        chk(1'b0, "R2 we without ce", ram_ce_n, 0);
      if (!ram_we_n) begin
        we_run <= we_run + 1;
        if (!ram_ce_n) begin
          if (!ram_be_n[0]) mem[ram_addr[7:0]][7:0]  <= ram_dq_out[7:0];
          if (!ram_be_n[1]) mem[ram_addr[7:0]][15:8] <= ram_dq_out[15:8];
        end
      end else if (we_run != 0) begin
        chk(we_run == WPULSE_CYC, "R2 pulse length", we_run, WPULSE_CYC);
        chk(ram_ce_n && (&ram_be_n), "R2 strobes rise together",
            {ram_ce_n, ram_be_n}, 3'h7);
        chk(ram_dq_oe == 1'b1, "R4 drive after rise", ram_dq_oe, 1);
        we_run <= 0;
      end
      post_we   <= (we_run != 0) && ram_we_n;
      prev_addr <= ram_addr;
      prev_idle <= ram_ce_n && ram_we_n && (&ram_be_n);
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [1:0] m,
                          input logic [15:0] d);
    int n;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_mask = m; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    chk(ram_ce_n && ram_we_n && ram_oe_n, "R2 settle strobes high",
        {ram_ce_n, ram_we_n, ram_oe_n}, 3'h7);
    @(negedge clk); n++;
    chk(!ram_ce_n && !ram_we_n && ram_oe_n && (ram_be_n == ~m),
        "R2 write strobes", {ram_ce_n, ram_we_n, ram_oe_n, ram_be_n},
        {3'b001, ~m});
    chk(ram_dq_out == d, "R4 write data", ram_dq_out, d);
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    chk(n == SETUP_CYC + WPULSE_CYC + 2, "R10 write ready", n,
        SETUP_CYC + WPULSE_CYC + 2);
    sb[a[7:0]] = merge(m, sb[a[7:0]], d);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m,
                         input bit hold_valid);
    int n;
    logic [15:0] exp;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_mask = m;
    @(negedge clk);
    n = 1;
    if (hold_valid) begin
      req_addr = a ^ 20'h0F0F0;
      req_write = 1'b1;
      @(negedge clk); n++;
      chk(!req_ready && ram_addr == a, "R9 busy ignores request", ram_addr, a);
      chk(!ram_ce_n && !ram_oe_n && ram_we_n && ram_be_n == ~m, "R6 read strobes",
          {ram_ce_n, ram_oe_n, ram_we_n, ram_be_n}, {3'b001, ~m});
    end
    req_valid = 1'b0;
    while (!rdata_valid && n < 50) begin @(negedge clk); n++; end
    chk(n == SETUP_CYC + RWAIT_CYC + 2, "R6 read latency", n, SETUP_CYC + RWAIT_CYC + 2);
    exp = lane_keep(m, sb[a[7:0]]);
    chk(rdata == exp, "R7 R8 read data", rdata, exp);
    chk(!req_ready && ram_ce_n && ram_oe_n && (&ram_be_n), "R9 turnaround idle",
        {req_ready, ram_ce_n, ram_oe_n, ram_be_n}, 5'b01111);
    @(negedge clk);
    chk(!rdata_valid, "R6 single pulse", rdata_valid, 0);
    if (hold_valid) chk(req_ready, "R9 ready after turn", req_ready, 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) sb[i] = 16'h0000;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_mask = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && ram_ce_n && ram_we_n && ram_oe_n && (&ram_be_n) &&
        !ram_dq_oe && !rdata_valid, "R1 in reset",
        {req_ready, ram_ce_n, ram_we_n, ram_oe_n, ram_be_n, ram_dq_oe, rdata_valid},
        8'b11111100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    chk(req_ready && ram_ce_n && ram_we_n && ram_oe_n && (&ram_be_n) &&
        !ram_dq_oe && !rdata_valid, "R1 after release",
        {req_ready, ram_ce_n, ram_we_n, ram_oe_n, ram_be_n, ram_dq_oe, rdata_valid},
        8'b11111100);

    // Directed corners.
    do_write(20'h00010, 2'b11, 16'hBEEF);
    do_write(20'h00010, 2'b01, 16'h1234);   // R8: upper byte must stay BE
    do_read (20'h00010, 2'b11, 1'b0);
    do_write(20'h00010, 2'b00, 16'hFFFF);   // R8: nothing written
    do_read (20'h00010, 2'b11, 1'b0);
    do_read (20'h00010, 2'b10, 1'b0);       // R7: lower lane zero
    do_read (20'h00010, 2'b00, 1'b0);       // R7: both zero
    do_write(20'hFFFFF, 2'b10, 16'hA100);
    do_read (20'hFFFFF, 2'b11, 1'b1);       // R9: valid held while busy
    do_read (20'h00000, 2'b01, 1'b0);

    // Constrained random mix.
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      logic [1:0]    m;
      a = {12'($urandom), 8'($urandom_range(0, 31))};
      m = 2'($urandom);
      if ($urandom_range(0, 1) == 0) do_write(a, m, 16'($urandom));
      else                           do_read(a, m, $urandom_range(0, 7) == 0);
    end

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule